// File: doc/BRIEF.md
# Hardware Thread Switch Controller

This block decides, every clock, which of several hardware thread contexts supplies the next instruction to a single-issue pipeline. Each context has its own program counter and register state. A switch therefore needs only a new context select, with no save or restore of state. The controller drives a one-hot select that the fetch and register-file muxes use directly.

The controller has two policies, chosen by a mode input. In interleaved mode it moves to a new thread on every clock in round-robin order and passes over any thread that reports a stall. In switch-on-miss mode it stays on one thread until that thread reports a costly stall, such as a second-level cache miss. It then asks the pipeline to drain, waits for the pipeline to report that it is empty, and selects the next ready thread. It then lets that thread issue for a fixed refill period while completion is held off. A saturating counter keeps the number of cycles spent draining, switching and refilling.

Top module: `thread_switch_ctrl`

## Requirements
- R1: While reset is asserted the lost-cycle counter reads 0 and the controller is in its running state. The round-robin pointer is set so that, when all threads are ready, the first interleaved pick is thread 0.
- R2: In interleaved mode (`coarseMode` = 0), with all threads ready, `issueThread` advances by one each clock (0, 1, 2, 3, 0, ...) and `issueValid` is 1.
- R3: In interleaved mode a thread with either `threadStall` or `threadLongStall` set is skipped. The pick is the first ready thread after the last issued one, wrapping around. A stalled thread is never issued in either mode.
- R4: When no thread is ready, `issueValid` is 0 and `pcSelect` is all zero. The pointer holds, so the next pick continues after the last thread actually issued.
- R5: In switch-on-miss mode, while running, the same thread stays selected. A short stall (`threadStall`) on it gives a bubble (`issueValid` = 0) and no switch. Stalls on other threads have no effect.
- R6: A costly stall (`threadLongStall`) on the current thread in the running state gives a bubble in that cycle. It then enters a drain phase with `flushReq` = 1 and no issue, and the drain lasts until `pipeEmpty` is sampled high.
- R7: After the drain, one switch cycle selects the first thread after the current one, in round-robin order, that has neither stall input set. If none is ready, the switch cycle repeats, with bubbles, until one is.
- R8: After a switch the new thread issues for exactly `REFILL_CYCLES` cycles with `commitEn` = 0, and then returns to the running state with `commitEn` = 1. `commitEn` is also 0 in the switch cycle and 1 during the drain.
- R9: `lostCycles` increments by one for every drain, switch and refill cycle, saturates at its maximum, and never counts in interleaved mode.
- R10: `pcSelect` is the one-hot decode of `issueThread` when `issueValid` is 1 and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coarseMode | input | 1 | 0 = interleave every clock, 1 = switch only on costly stall |
| threadStall | input | NUM_THREADS | Per-thread short stall |
| threadLongStall | input | NUM_THREADS | Per-thread costly stall |
| pipeEmpty | input | 1 | Pipeline reports no instructions in flight |
| issueValid | output | 1 | A thread is selected this cycle |
| issueThread | output | TW | Selected thread index |
| pcSelect | output | NUM_THREADS | One-hot program-counter / context select |
| flushReq | output | 1 | Drain/freeze request to the pipeline |
| commitEn | output | 1 | Instructions may complete |
| lostCycles | output | LOST_W | Saturating count of switch-penalty cycles |

## Verification
The hardest case to reach is a switch cycle in which no context is ready. This requires a costly stall on the current thread, a completed drain, and short stalls on every other thread, all at the same time. The stimulus holds the pipeline non-empty for a cycle so that the drain length can be seen. It then stalls all remaining threads for two switch cycles and releases them, which checks the wrap-around pick and the exact penalty count. It also issues a short stall in the running state to show that a bubble alone does not cause a switch.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SWITCH = 2'd2,
    ST_REFILL = 2'd3
  } tscState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takePick;    // load curThread with the round-robin pick
    logic loadRefill;  // start the refill countdown
    logic decRefill;   // count one refill cycle
    logic countLost;   // this cycle is a switch penalty cycle
    logic useCur;      // issue the held thread instead of the pick
  } tscStrobe_t;

endpackage

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int REFILL_CYCLES = 3,
  parameter int LOST_W        = 16,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW = $clog2(REFILL_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tscStrobe_t             strobe,
  input  logic [NUM_THREADS-1:0] threadStall,
  input  logic [NUM_THREADS-1:0] threadLongStall,
  output logic [TW-1:0]          pickThread,
  output logic [TW-1:0]          curThread,
  output logic                   anyReady,
  output logic                   curStalled,
  output logic                   curLongStall,
  output logic                   refillLast,
  output logic [LOST_W-1:0]      lostCycles
);

  logic [NUM_THREADS-1:0] readyVec;
  logic [CW-1:0]          refillCnt;
  int                     scanIdx;

  assign readyVec = ~(threadStall | threadLongStall);

  // first ready thread after curThread, wrapping; curThread itself last
  always_comb begin
    pickThread = curThread;
    anyReady   = 1'b0;
    scanIdx    = 0;
    for (int k = NUM_THREADS; k >= 1; k--) begin
      scanIdx = (int'(curThread) + k) % NUM_THREADS;
      if (readyVec[scanIdx]) begin
        pickThread = TW'(scanIdx);
        anyReady   = 1'b1;
      end
    end
  end

  assign curStalled   = threadStall[curThread];
  assign curLongStall = threadLongStall[curThread];
  assign refillLast   = (refillCnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curThread <= TW'(NUM_THREADS - 1);
    end else if (strobe.takePick) begin
      curThread <= pickThread;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refillCnt <= '0;
    end else if (strobe.loadRefill) begin
      refillCnt <= CW'(REFILL_CYCLES);
    end else if (strobe.decRefill && refillCnt != '0) begin
      refillCnt <= refillCnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lostCycles <= '0;
    end else if (strobe.countLost && lostCycles != {LOST_W{1'b1}}) begin
      lostCycles <= lostCycles + LOST_W'(1);
    end
  end

  // R9: penalty counter never goes backwards
  a_r9_lost_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lostCycles >= $past(lostCycles));

  // R4: with nothing ready the pointer holds
  a_r4_hold_pointer: assert property (@(posedge clk) disable iff (!rstN)
    !anyReady |=> $stable(curThread));

endmodule

// File: rtl/tsc_control.sv
module tsc_control
  import tsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coarseMode,
  input  logic       pipeEmpty,
  input  logic       anyReady,
  input  logic       curStalled,
  input  logic       curLongStall,
  input  logic       refillLast,
  output tscStrobe_t strobe,
  output logic       issueOn,
  output logic       flushReq,
  output logic       commitEn
);

  tscState_e state, nextState;

  always_comb begin
    strobe    = '0;
    issueOn   = 1'b0;
    flushReq  = 1'b0;
    commitEn  = 1'b1;
    nextState = state;
    if (!coarseMode) begin
      nextState       = ST_RUN;
      issueOn         = anyReady;
      strobe.takePick = anyReady;
    end else begin
      strobe.useCur = 1'b1;
      case (state)
        ST_RUN: begin
          issueOn = !curStalled && !curLongStall;
          if (curLongStall) nextState = ST_DRAIN;
        end
        ST_DRAIN: begin
          flushReq         = 1'b1;
          strobe.countLost = 1'b1;
          if (pipeEmpty) nextState = ST_SWITCH;
        end
        ST_SWITCH: begin
          commitEn         = 1'b0;
          strobe.countLost = 1'b1;
          if (anyReady) begin
            strobe.takePick   = 1'b1;
            strobe.loadRefill = 1'b1;
            nextState         = ST_REFILL;
          end
        end
        ST_REFILL: begin
          commitEn         = 1'b0;
          strobe.countLost = 1'b1;
          strobe.decRefill = 1'b1;
          issueOn          = !curStalled && !curLongStall;
          if (refillLast) nextState = ST_RUN;
        end
        default: nextState = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  // R8: refill ends after its last counted cycle
  a_r8_refill_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFILL && refillLast) |=> state == ST_RUN);

  // R6: drain persists until the pipeline is empty
  a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && state == ST_DRAIN && !pipeEmpty) |=>
      (state == ST_DRAIN || state == ST_RUN));

  // R7: a switch only lands on a ready thread
  a_r7_switch_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWITCH && nextState == ST_REFILL) |-> anyReady);

endmodule

// File: rtl/thread_switch_ctrl.sv
module thread_switch_ctrl
  import tsc_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int REFILL_CYCLES = 3,
  parameter int LOST_W        = 16,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coarseMode,
  input  logic [NUM_THREADS-1:0] threadStall,
  input  logic [NUM_THREADS-1:0] threadLongStall,
  input  logic                   pipeEmpty,
  output logic                   issueValid,
  output logic [TW-1:0]          issueThread,
  output logic [NUM_THREADS-1:0] pcSelect,
  output logic                   flushReq,
  output logic                   commitEn,
  output logic [LOST_W-1:0]      lostCycles
);

  tscStrobe_t    strobe;
  logic [TW-1:0] pickThread, curThread;
  logic          anyReady, curStalled, curLongStall, refillLast, issueOn;

  tsc_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .coarseMode   (coarseMode),
    .pipeEmpty    (pipeEmpty),
    .anyReady     (anyReady),
    .curStalled   (curStalled),
    .curLongStall (curLongStall),
    .refillLast   (refillLast),
    .strobe       (strobe),
    .issueOn      (issueOn),
    .flushReq     (flushReq),
    .commitEn     (commitEn)
  );

  tsc_datapath #(
    .NUM_THREADS   (NUM_THREADS),
    .REFILL_CYCLES (REFILL_CYCLES),
    .LOST_W        (LOST_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .threadStall     (threadStall),
    .threadLongStall (threadLongStall),
    .pickThread      (pickThread),
    .curThread       (curThread),
    .anyReady        (anyReady),
    .curStalled      (curStalled),
    .curLongStall    (curLongStall),
    .refillLast      (refillLast),
    .lostCycles      (lostCycles)
  );

  assign issueValid  = issueOn;
  assign issueThread = strobe.useCur ? curThread : pickThread;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_pcsel
    assign pcSelect[g] = issueValid && (issueThread == TW'(g));
  end

  // R10: select is one-hot exactly when issuing
  a_r10_pcsel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pcSelect) && (issueValid == (|pcSelect)));

  // R3: never issue a stalled thread
  a_r3_issue_ready: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !(threadStall[issueThread] || threadLongStall[issueThread]));

  // R6: no issue while draining
  a_r6_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !issueValid);

endmodule

// File: tb/sim_thread_switch_ctrl.sv
`timescale 1ns/1ps
module sim_thread_switch_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       coarseMode = 1'b0;
  logic [3:0] threadStall = '0;
  logic [3:0] threadLongStall = '0;
  logic       pipeEmpty = 1'b0;
  logic       issueValid;
  logic [1:0] issueThread;
  logic [3:0] pcSelect;
  logic       flushReq, commitEn;
  logic [15:0] lostCycles;

  always #4 clk = ~clk;

  thread_switch_ctrl #(.NUM_THREADS(4), .REFILL_CYCLES(3), .LOST_W(16)) u0 (
    .clk(clk), .rstN(rstN), .coarseMode(coarseMode),
    .threadStall(threadStall), .threadLongStall(threadLongStall),
    .pipeEmpty(pipeEmpty), .issueValid(issueValid), .issueThread(issueThread),
    .pcSelect(pcSelect), .flushReq(flushReq), .commitEn(commitEn),
    .lostCycles(lostCycles)
  );

  typedef struct {
    logic  valid;
    int    thread;
    logic  flush;
    logic  commit;
    int    lost;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  vecCount = 0;
  int  errCount = 0;
  bit  doneFlag = 1'b0;

  task automatic step(input logic cm, input logic [3:0] st, input logic [3:0] lg,
                      input logic pe, input logic ev, input int et,
                      input logic ef, input logic ec, input int el, input string rq);
    expItem_t it;
    @(negedge clk);
    coarseMode = cm; threadStall = st; threadLongStall = lg; pipeEmpty = pe;
    it.valid = ev; it.thread = et; it.flush = ef; it.commit = ec; it.lost = el; it.req = rq;
    expQ.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    expItem_t it;
    logic [3:0] expSel;
    #3;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      expSel = it.valid ? (4'b0001 << it.thread) : 4'b0000;
      vecCount++;
      if (issueValid !== it.valid || (it.valid && int'(issueThread) != it.thread) ||
          pcSelect !== expSel || flushReq !== it.flush || commitEn !== it.commit ||
          int'(lostCycles) != it.lost) begin
        errCount++;
        $display("FAIL %s: got v=%0b t=%0d sel=%b f=%0b c=%0b lost=%0d exp v=%0b t=%0d sel=%b f=%0b c=%0b lost=%0d",
                 it.req, issueValid, issueThread, pcSelect, flushReq, commitEn, lostCycles,
                 it.valid, it.thread, expSel, it.flush, it.commit, it.lost);
      end
    end
  end

  initial begin
    #(2000 * 8);
    if (!doneFlag) begin
      errCount++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(0, 4'h0, 4'h0, 0, 1, 0, 0, 1, 0, "R1");
    rstN = 1'b1;
    // R2 plain round robin
    step(0, 4'h0, 4'h0, 0, 1, 1, 0, 1, 0, "R2");
    step(0, 4'h0, 4'h0, 0, 1, 2, 0, 1, 0, "R2");
    step(0, 4'h0, 4'h0, 0, 1, 3, 0, 1, 0, "R2");
    step(0, 4'h0, 4'h0, 0, 1, 0, 0, 1, 0, "R2 wrap");
    // R3 skip short-stalled thread 1
    step(0, 4'b0010, 4'h0, 0, 1, 2, 0, 1, 0, "R3");
    step(0, 4'b0010, 4'h0, 0, 1, 3, 0, 1, 0, "R3");
    step(0, 4'b0010, 4'h0, 0, 1, 0, 0, 1, 0, "R3");
    step(0, 4'b0010, 4'h0, 0, 1, 2, 0, 1, 0, "R3");
    // R3 skip long-stalled thread 3
    step(0, 4'h0, 4'b1000, 0, 1, 0, 0, 1, 0, "R3 long");
    step(0, 4'h0, 4'b1000, 0, 1, 1, 0, 1, 0, "R3 long");
    step(0, 4'h0, 4'b1000, 0, 1, 2, 0, 1, 0, "R3 long");
    step(0, 4'h0, 4'b1000, 0, 1, 0, 0, 1, 0, "R3 long");
    // R4 all stalled: bubble, pointer held
    step(0, 4'hF, 4'h0, 0, 0, 0, 0, 1, 0, "R4");
    step(0, 4'h3, 4'hC, 0, 0, 0, 0, 1, 0, "R4");
    step(0, 4'h0, 4'h0, 0, 1, 1, 0, 1, 0, "R4 resume");
    // R5 coarse: hold thread 1, short stall is a bubble only
    step(1, 4'h0, 4'h0, 0, 1, 1, 0, 1, 0, "R5");
    step(1, 4'b0010, 4'h0, 0, 0, 0, 0, 1, 0, "R5 bubble");
    step(1, 4'b0100, 4'h0, 0, 1, 1, 0, 1, 0, "R5 other stall");
    // R6 costly stall on thread 1, drain two cycles
    step(1, 4'h0, 4'b0010, 0, 0, 0, 0, 1, 0, "R6 trigger");
    step(1, 4'h0, 4'b0010, 0, 0, 0, 1, 1, 0, "R6 drain");
    step(1, 4'h0, 4'b0010, 1, 0, 0, 1, 1, 1, "R6 drain empty");
    // R7 switch skips stalled thread 2, lands on 3
    step(1, 4'b0100, 4'b0010, 1, 0, 0, 0, 0, 2, "R7");
    // R8 refill three cycles, no commit
    step(1, 4'h0, 4'h0, 1, 1, 3, 0, 0, 3, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 3, 0, 0, 4, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 3, 0, 0, 5, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 3, 0, 1, 6, "R8 run R9");
    // R7 switch waits while nothing is ready, then wraps to thread 0
    step(1, 4'h0, 4'b1000, 1, 0, 0, 0, 1, 6, "R6 trigger2");
    step(1, 4'h0, 4'b1000, 1, 0, 0, 1, 1, 6, "R6 drain2");
    step(1, 4'b0111, 4'b1000, 1, 0, 0, 0, 0, 7, "R7 wait");
    step(1, 4'b0111, 4'b1000, 1, 0, 0, 0, 0, 8, "R7 wait");
    step(1, 4'h0, 4'b1000, 1, 0, 0, 0, 0, 9, "R7 wrap");
    step(1, 4'h0, 4'h0, 1, 1, 0, 0, 0, 10, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 0, 0, 0, 11, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 0, 0, 0, 12, "R8");
    step(1, 4'h0, 4'h0, 1, 1, 0, 0, 1, 13, "R9 total");
    // R9 interleaved mode does not count penalty; R10 checked on every vector
    step(0, 4'h0, 4'h0, 0, 1, 1, 0, 1, 13, "R9 fine R10");
    step(0, 4'h0, 4'h0, 0, 1, 2, 0, 1, 13, "R9 fine R10");
    @(negedge clk);
    @(negedge clk);
    doneFlag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule